// File: doc/BRIEF.md
# Cosine Coefficient Scaling Multiplier Stage

This block sits between two butterfly stages of a sequential 8-point inverse cosine transform pipeline. Samples arrive one per clock as signed fixed-point fractions with a valid flag. Each sample is multiplied by a constant that depends on where the sample falls in its 8-sample frame. The result is then brought back to the internal word width, with a left shift applied as a gain.

The constants form a family of cosines. The family starts at the square root of one half. Each later member is the square root of one half of (1 + d) or of (1 - d), where d is an earlier member. Those constants are rounded once to the data width.

Requantization has two run-time modes, chosen per sample. One is round-to-nearest on a coarser grid. The other is truncation toward minus infinity on the full grid. Both modes saturate on overflow. Valid, data and frame position leave the stage three clock edges after they enter.

Top module: `scale_mult_stage`

## Requirements
- R1: The table holds constants d1..d7, with d1 = sqrt(0.5), d(2i) = sqrt(0.5(1+d(i))) and d(2i+1) = sqrt(0.5(1-d(i))). Each constant is rounded to nearest as a signed fraction with DATA_W-1 fraction bits. Frame position k (1..7) uses d(k), and position 0 uses d1.
- R2: A position counter starts at 0 after reset and advances by one on every cycle with in_valid high. It wraps from 7 to 0 and holds on idle cycles. out_idx reports the position used for the sample being presented.
- R3: A sample captured at rising edge n appears on out_valid/out_data/out_idx after rising edge n+2, the third register stage. out_valid equals in_valid delayed by those three edges.
- R4: In both modes the exact value being quantized is x * d * 2^GAIN_SHL, with x taken as a fraction of DATA_W-1 fraction bits. GAIN_SHL defaults to 1. As a result, a positive input never gives a negative output and a negative input never gives a positive output.
- R5: With in_rnd = 1, the value is rounded to the nearest multiple of 2^-(RND_W-1), with ties going up. RND_W defaults to 17. The DATA_W-RND_W low bits of out_data are then zero.
- R6: With in_rnd = 0, the value is truncated toward minus infinity to a multiple of 2^-(DATA_W-1). DATA_W defaults to 22.
- R7: A result above the largest value of the active mode's grid is replaced by that largest value. A result below -1 is replaced by -1.
- R8: After reset, out_valid, out_data and out_idx are 0. Whenever out_valid is 0, out_data is 0.
- R9: The mode is sampled together with each valid input. Changing in_rnd between samples changes only the samples captured with the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_data | input | DATA_W | Signed fraction, DATA_W-1 fraction bits |
| in_rnd | input | 1 | 1 = round to nearest on the coarse grid, 0 = truncate on the fine grid |
| out_valid | output | 1 | Output sample present |
| out_data | output | DATA_W | Scaled, requantized and saturated sample |
| out_idx | output | 3 | Frame position of the output sample |

## Verification
If the position counter slips, out_idx shows it on the first valid output, three edges after the faulty input. From then on, every sample in the frame also picks up the wrong constant. If a pipeline valid bit is stale, it shows as a lost sample or as nonzero data in an idle slot in the same cycle it reaches the output. A wrong rounding offset, shift amount or clamp limit is caught by the saturating extremes, the one-LSB inputs and the exact-half inputs. Each of these makes out_data differ from the bench model in its first valid output.

// File: rtl/scale_mult_pkg.sv
// Package: shared constant functions for the coefficient scaling stage.
// Assumes frame positions below 64 and fraction widths below 31.
package scale_mult_pkg;

    // Cosine family member for frame position k (position 0 maps to member 1).
    function automatic real half_angle_coef(input int k);
        real d [64];
        int  top;
        top  = (k < 1) ? 1 : k;
        d[0] = 0.0;
        d[1] = $sqrt(0.5);
        for (int i = 2; i < 64; i++) begin
            if (i <= top) begin
                if (i % 2 == 0) d[i] = $sqrt(0.5 * (1.0 + d[i / 2]));
                else            d[i] = $sqrt(0.5 * (1.0 - d[i / 2]));
            end else begin
                d[i] = 0.0;
            end
        end
        return d[top];
    endfunction

    // Round-to-nearest integer code of the member with frac fraction bits.
    function automatic int coef_code(input int k, input int frac);
        return $rtoi(half_angle_coef(k) * (2.0 ** frac) + 0.5);
    endfunction

endpackage

// File: rtl/scale_coef_rom.sv
// Module: frame position counter and constant coefficient table.
// Assumes coefficients lie in (0,1) and fit a DATA_W signed fraction.
module scale_coef_rom #(
    parameter int DATA_W    = 22,
    parameter int FRAME_LEN = 8,
    localparam int IDX_W    = $clog2(FRAME_LEN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv,
    output logic [IDX_W-1:0]         pos,
    output logic signed [DATA_W-1:0] coef
);
    localparam int FRAC_W = DATA_W - 1;

    logic signed [DATA_W-1:0] table_q [FRAME_LEN];

    // One constant per frame position, computed at elaboration.
    generate
        for (genvar g = 0; g < FRAME_LEN; g++) begin : g_entry
            localparam int CODE = scale_mult_pkg::coef_code(g, FRAC_W);
            assign table_q[g] = DATA_W'(CODE);
        end
    endgenerate

    // Advance the frame position on each accepted sample, wrapping at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (adv)
            pos <= (pos == IDX_W'(FRAME_LEN - 1)) ? '0 : pos + 1'b1;
    end

    // Select the constant for the current position.
    always_comb coef = table_q[pos];

endmodule

// File: rtl/scale_requant.sv
// Module: requantizes a full-width product in one of two modes, with saturation.
// Assumes GAIN_SHL < DATA_W-1 and RND_W < DATA_W; combinational only.
module scale_requant #(
    parameter int DATA_W   = 22,
    parameter int RND_W    = 17,
    parameter int GAIN_SHL = 1,
    localparam int PROD_W  = 2 * DATA_W
) (
    input  logic signed [PROD_W-1:0] prod,
    input  logic                     rnd,
    output logic signed [DATA_W-1:0] y
);
    localparam int F_W   = DATA_W - 1;
    localparam int R_W   = RND_W - 1;
    localparam int SH_R  = 2 * F_W - GAIN_SHL - R_W;
    localparam int SH_T  = F_W - GAIN_SHL;
    localparam int PAD_W = F_W - R_W;

    localparam logic signed [PROD_W-1:0] HALF  = PROD_W'(1) << (SH_R - 1);
    localparam logic signed [PROD_W-1:0] R_MAX = {{(PROD_W-R_W){1'b0}}, {R_W{1'b1}}};
    localparam logic signed [PROD_W-1:0] R_MIN = {{(PROD_W-R_W){1'b1}}, {R_W{1'b0}}};
    localparam logic signed [PROD_W-1:0] T_MAX = {{(PROD_W-F_W){1'b0}}, {F_W{1'b1}}};
    localparam logic signed [PROD_W-1:0] T_MIN = {{(PROD_W-F_W){1'b1}}, {F_W{1'b0}}};

    logic signed [PROD_W-1:0] sum_r, q_r, q_t;
    logic signed [DATA_W-1:0] y_r, y_t;

    // Round mode: add half a coarse LSB, shift, clamp and left-align.
    always_comb begin
        sum_r = prod + HALF;
        q_r   = sum_r >>> SH_R;
        if (q_r > R_MAX)
            y_r = {1'b0, {R_W{1'b1}}, {PAD_W{1'b0}}};
        else if (q_r < R_MIN)
            y_r = {1'b1, {R_W{1'b0}}, {PAD_W{1'b0}}};
        else
            y_r = {q_r[R_W:0], {PAD_W{1'b0}}};
    end

    // Truncate mode: drop low bits (floor) and clamp.
    always_comb begin
        q_t = prod >>> SH_T;
        if (q_t > T_MAX)
            y_t = {1'b0, {F_W{1'b1}}};
        else if (q_t < T_MIN)
            y_t = {1'b1, {F_W{1'b0}}};
        else
            y_t = q_t[F_W:0];
    end

    // Pick the mode result.
    always_comb y = rnd ? y_r : y_t;

endmodule

// File: rtl/scale_mult_stage.sv
// Module: three-register coefficient scaling stage for a sequential 8-point
// inverse cosine transform. Stage 1 captures the sample with its constant,
// stage 2 forms the product, stage 3 requantizes. Assumes one sample per clock.
module scale_mult_stage #(
    parameter int DATA_W    = 22,
    parameter int RND_W     = 17,
    parameter int GAIN_SHL  = 1,
    parameter int FRAME_LEN = 8,
    localparam int IDX_W    = $clog2(FRAME_LEN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic                     in_rnd,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data,
    output logic [IDX_W-1:0]         out_idx
);
    localparam int PROD_W = 2 * DATA_W;

    logic [IDX_W-1:0]         pos;
    logic signed [DATA_W-1:0] coef;
    logic                     s1_valid, s1_rnd;
    logic signed [DATA_W-1:0] s1_data, s1_coef;
    logic [IDX_W-1:0]         s1_idx;
    logic                     s2_valid, s2_rnd;
    logic signed [PROD_W-1:0] s2_prod;
    logic [IDX_W-1:0]         s2_idx;
    logic signed [DATA_W-1:0] y;

    scale_coef_rom #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) u_rom (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (in_valid),
        .pos  (pos),
        .coef (coef)
    );

    // Stage 1: capture the sample, its mode, its position and its constant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_rnd   <= 1'b0;
            s1_data  <= '0;
            s1_coef  <= '0;
            s1_idx   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_rnd   <= in_rnd;
            s1_data  <= in_data;
            s1_coef  <= coef;
            s1_idx   <= pos;
        end
    end

    // Stage 2: full-precision signed product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_rnd   <= 1'b0;
            s2_prod  <= '0;
            s2_idx   <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_rnd   <= s1_rnd;
            s2_prod  <= PROD_W'(s1_data) * PROD_W'(s1_coef);
            s2_idx   <= s1_idx;
        end
    end

    scale_requant #(.DATA_W(DATA_W), .RND_W(RND_W), .GAIN_SHL(GAIN_SHL)) u_rq (
        .prod(s2_prod),
        .rnd (s2_rnd),
        .y   (y)
    );

    // Stage 3: register the requantized result, zero in idle slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_idx   <= '0;
        end else begin
            out_valid <= s2_valid;
            out_data  <= s2_valid ? y : '0;
            out_idx   <= s2_idx;
        end
    end

endmodule

// File: rtl/scale_mult_stage_chk.sv
// Module: port-level checker for scale_mult_stage, attached by bind.
// Assumes RND_W < DATA_W; observes ports only.
module scale_mult_stage_chk #(
    parameter int DATA_W    = 22,
    parameter int RND_W     = 17,
    parameter int FRAME_LEN = 8,
    localparam int IDX_W    = $clog2(FRAME_LEN)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_data,
    input logic                     in_rnd,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_data,
    input logic [IDX_W-1:0]         out_idx
);
    localparam int PAD_W = DATA_W - RND_W;

    logic [1:0]       age;
    logic             seen;
    logic [IDX_W-1:0] last_idx;

    // Count edges since reset release, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n)       age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // Remember the position of the last valid output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen     <= 1'b0;
            last_idx <= '0;
        end else if (out_valid) begin
            seen     <= 1'b1;
            last_idx <= out_idx;
        end
    end

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0));

    p_first_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !seen) |-> (out_idx == '0));

    p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen) |->
        (out_idx == ((last_idx == IDX_W'(FRAME_LEN - 1)) ? '0 : last_idx + 1'b1)));

    p_round_grid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && out_valid && $past(in_rnd, 3)) |-> (out_data[PAD_W-1:0] == '0));

    p_sign_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && out_valid && $past(in_data, 3) >= 0) |-> (out_data >= 0));

    p_sign_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && out_valid && $past(in_data, 3) < 0) |-> (out_data <= 0));

endmodule

bind scale_mult_stage scale_mult_stage_chk #(
    .DATA_W(DATA_W), .RND_W(RND_W), .FRAME_LEN(FRAME_LEN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_rnd(in_rnd),
    .out_valid(out_valid), .out_data(out_data), .out_idx(out_idx)
);

// File: tb/scale_mult_stage_tb.sv
module scale_mult_stage_tb;
    localparam int DW = 22, RW = 17, GS = 1;
    localparam int F = DW - 1, R = RW - 1;
    localparam int SR = 2 * F - GS - R, ST = F - GS;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_rnd = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic out_valid;
    logic signed [DW-1:0] out_data;
    logic [2:0] out_idx;

    int total = 0, bad = 0;
    bit finished = 0;
    longint coef [8];
    bit     ev [3];
    longint ed [3];
    int     ei [3];
    string  et [3];
    int     bidx = 0;

    always #10 clk = ~clk;

    scale_mult_stage u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_rnd(in_rnd),
        .out_valid(out_valid), .out_data(out_data), .out_idx(out_idx)
    );

    // R1 model: cosine family rounded to F fraction bits
    function automatic void build_coefs();
        real d [8];
        d[1] = $sqrt(0.5);
        for (int i = 2; i < 8; i++)
            d[i] = (i % 2 == 0) ? $sqrt(0.5 * (1.0 + d[i/2])) : $sqrt(0.5 * (1.0 - d[i/2]));
        d[0] = d[1];
        for (int i = 0; i < 8; i++) coef[i] = longint'($rtoi(d[i] * (2.0 ** F) + 0.5));
    endfunction

    // R4-R7 model: gain, round or floor, clamp
    function automatic longint ref_q(longint x, int k, bit rnd, output bit sat);
        longint p, q, lo, hi;
        p = x * coef[k];
        if (rnd) begin
            q  = (p + (longint'(1) <<< (SR - 1))) >>> SR;
            lo = -(longint'(1) <<< R);
            hi = (longint'(1) <<< R) - 1;
        end else begin
            q  = p >>> ST;
            lo = -(longint'(1) <<< F);
            hi = (longint'(1) <<< F) - 1;
        end
        sat = (q > hi) || (q < lo);
        if (q > hi) q = hi;
        if (q < lo) q = lo;
        return rnd ? (q <<< (F - R)) : q;
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(bit v, longint x, bit rnd, string tag);
        bit s;
        @(negedge clk);
        chk(out_valid == ev[2], "R3", "out_valid", longint'(out_valid), longint'(ev[2]));
        if (ev[2]) begin
            chk(longint'(out_data) == ed[2], et[2], "out_data", longint'(out_data), ed[2]);
            chk(int'(out_idx) == ei[2], "R2", "out_idx", longint'(out_idx), longint'(ei[2]));
        end else begin
            chk(out_data == '0, "R8", "idle out_data", longint'(out_data), 0);
        end
        for (int i = 2; i > 0; i--) begin
            ev[i] = ev[i-1]; ed[i] = ed[i-1]; ei[i] = ei[i-1]; et[i] = et[i-1];
        end
        ev[0] = v; ed[0] = 0; ei[0] = 0; et[0] = "R8";
        if (v) begin
            ed[0] = ref_q(x, bidx, rnd, s);
            ei[0] = bidx;
            et[0] = (tag != "") ? tag : (s ? "R7" : (rnd ? "R5" : "R6"));
            bidx  = (bidx + 1) % 8;
        end
        in_valid = v;
        in_data  = DW'(x);
        in_rnd   = rnd;
    endtask

    function automatic longint rnd_x();
        logic signed [DW-1:0] t;
        t = DW'($urandom);
        return longint'(t);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        build_coefs();
        for (int i = 0; i < 3; i++) begin ev[i] = 0; ed[i] = 0; ei[i] = 0; et[i] = "R8"; end
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(out_valid == 1'b0, "R8", "reset out_valid", longint'(out_valid), 0);
        chk(out_data == '0, "R8", "reset out_data", longint'(out_data), 0);
        chk(out_idx == '0, "R8", "reset out_idx", longint'(out_idx), 0);
        rst_n = 1'b1;
        // R1: x = 0.5 with gain 2 reproduces each table constant (truncate mode)
        for (int k = 0; k < 8; k++) step(1, longint'(1) <<< (F - 1), 0, "R1");
        // R4: x = 0.25 in round mode gives half of each constant on the coarse grid
        for (int k = 0; k < 8; k++) step(1, longint'(1) <<< (F - 2), 1, "R4");
        // R2: idle gaps hold the position counter
        for (int k = 0; k < 5; k++) begin
            step(1, rnd_x(), k[0], "R2");
            step(0, 0, 0, "");
            step(0, 0, 0, "");
        end
        // R7: both extremes in both modes across a full frame
        for (int k = 0; k < 8; k++) step(1, (longint'(1) <<< F) - 1, 1, "");
        for (int k = 0; k < 8; k++) step(1, (longint'(1) <<< F) - 1, 0, "");
        for (int k = 0; k < 8; k++) step(1, -(longint'(1) <<< F), 1, "");
        for (int k = 0; k < 8; k++) step(1, -(longint'(1) <<< F), 0, "");
        // R5/R6: one-LSB inputs, rounding toward zero vs floor
        for (int k = 0; k < 8; k++) begin
            step(1, 1, k[0], "");
            step(1, -1, k[0], "");
            step(1, 3, k[1], "");
            step(1, -3, k[1], "");
        end
        // R9: mode alternating sample by sample
        for (int k = 0; k < 16; k++) step(1, rnd_x(), k[0], "R9");
        // random traffic
        for (int k = 0; k < 600; k++) step(($urandom % 4) != 0, rnd_x(), $urandom % 2, "");
        for (int k = 0; k < 4; k++) step(0, 0, 0, "");
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule